// File: doc/BRIEF.md
# Load Queue with Memory-Ordering Violation Check

This block keeps the in-flight loads of an out-of-order core in a circular queue. Loads enter at the tail in program order, each carrying a sequence number and the store-queue tail position seen at allocation. When a load executes, its effective address is written back into its slot.

When a store executes, it presents the load-queue position it captured at its own allocation, together with its address. The queue walks from that position toward the tail and looks for an executed load whose address falls in the same 256-byte block. The first such load found is a load that ran ahead of an older store. It is reported once as the violator, and the store gets a fault response in the same cycle.

Loads leave at the head when commit covers their sequence number. A squash trims younger loads off the tail. A single stall marker names a load waiting on a store. The marker is dropped when that store releases it or when the load is squashed.

Top module: `load_order_queue`

## Requirements
- R1: The ring holds at most DEPTH-1 loads; `alloc_ready` is low exactly when tail+1 equals head, and an allocation offered while it is low changes neither `lq_count` nor `lq_tail`.
- R2: An allocated load stores its sequence number and the offered store-queue tag; when `alloc_sq_empty` is high the tag is marked invalid (`head_sq_valid` reads 0 once the load reaches the head).
- R3: A load matches a store check only after its address has been written back through `wb_valid`/`wb_idx`; a freshly allocated slot holds no valid address.
- R4: A store check considers only slots from `chk_start` forward, wrapping past index DEPTH-1 to 0, up to but not including `lq_tail`; `chk_start` equal to `lq_tail` checks nothing.
- R5: A load matches when its address with bits [7:0] removed equals the check address with bits [7:0] removed.
- R6: `chk_fault` rises combinationally in the cycle of the check when a match exists and no violator is pending; the next cycle `viol_valid` is 1 with `viol_idx`/`viol_seq` naming the first match in walk order.
- R7: While a violator is pending, checks give no fault and do not replace it; a cycle with `viol_read` high clears `viol_valid` for the next cycle.
- R8: A commit removes, in one cycle, every load from the head whose sequence number is at most `commit_seq`.
- R9: A squash removes every load whose sequence number exceeds `squash_seq` and moves the tail back by that many slots; an allocation offered in the same cycle is dropped.
- R10: `stalled` is set by `stall_set`, cleared by `stall_release`, and also cleared when the stalled load is removed by a squash.
- R11: `lq_count` reflects every head or tail movement in the cycle after it is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a load at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_sq_tag | input | SQ_W | Store-queue tail at allocation |
| alloc_sq_empty | input | 1 | Store queue empty; tag is invalid |
| alloc_ready | output | 1 | A slot is free |
| lq_tail | output | IW | Current tail index (slot of the next load) |
| wb_valid | input | 1 | Write back a load address |
| wb_idx | input | IW | Slot being written |
| wb_addr | input | ADDR_W | Effective address |
| chk_valid | input | 1 | Store check request |
| chk_start | input | IW | Load position captured by the store |
| chk_addr | input | ADDR_W | Store address |
| chk_fault | output | 1 | Violation response to the store |
| viol_valid | output | 1 | Violator pending |
| viol_idx | output | IW | Slot of the violator |
| viol_seq | output | SEQ_W | Sequence number of the violator |
| viol_read | input | 1 | Consume the violator |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Loads younger than this are removed |
| stall_set | input | 1 | Mark a load as stalled |
| stall_idx | input | IW | Slot of the stalled load |
| stall_release | input | 1 | Store that held the stall has completed |
| stalled | output | 1 | A load is stalled |
| lq_count | output | IW+1 | Loads held |
| head_seq | output | SEQ_W | Sequence number at the head |
| head_sq_valid | output | 1 | Head load has a valid store tag |
| head_sq_tag | output | SQ_W | Store tag of the head load |

## Verification
The check is swept over every start position against every target slot, with some slots lacking an address. This separates range errors from address-valid errors. Check addresses share only the upper bits with their target, and probes one step beyond the 256-byte block show whether the low-bit masking is exact. Two loads in the same block, probed from different starts, show first-match order and whether a pending violator is overwritten. A wrapped queue shows whether the walk crosses index zero and stops at the tail. Squashes that miss and then hit the stalled load, with an allocation offered at the same time, cover squash priority and stall clearing.

// File: rtl/load_order_queue.sv
`timescale 1ns/1ps
module load_order_queue #(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 32,
  parameter int SEQ_W     = 8,
  parameter int SQ_W      = 3,
  parameter int DROP_BITS = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic [SQ_W-1:0]   alloc_sq_tag,
  input  logic              alloc_sq_empty,
  output logic              alloc_ready,
  output logic [IW-1:0]     lq_tail,
  input  logic              wb_valid,
  input  logic [IW-1:0]     wb_idx,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic              chk_valid,
  input  logic [IW-1:0]     chk_start,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_fault,
  output logic              viol_valid,
  output logic [IW-1:0]     viol_idx,
  output logic [SEQ_W-1:0]  viol_seq,
  input  logic              viol_read,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              stall_set,
  input  logic [IW-1:0]     stall_idx,
  input  logic              stall_release,
  output logic              stalled,
  output logic [CW-1:0]     lq_count,
  output logic [SEQ_W-1:0]  head_seq,
  output logic              head_sq_valid,
  output logic [SQ_W-1:0]   head_sq_tag
);

  logic [SEQ_W-1:0]  e_seq  [DEPTH];
  logic [ADDR_W-1:0] e_addr [DEPTH];
  logic [SQ_W-1:0]   e_sq   [DEPTH];
  logic [DEPTH-1:0]  e_av, e_sqv, occ;

  logic [IW-1:0] head, tail, stall_r;
  logic [CW-1:0] cnt, n_com, n_sq;
  logic          stall_v, hit, alloc_fire, stall_squashed;
  logic [IW-1:0] hit_idx, span, pos, rel;

  assign lq_tail       = tail;
  assign lq_count      = cnt;
  assign stalled       = stall_v;
  assign alloc_ready   = (tail + IW'(1)) != head;
  assign alloc_fire    = alloc_valid && alloc_ready && !squash_valid;
  assign head_seq      = e_seq[head];
  assign head_sq_valid = e_sqv[head];
  assign head_sq_tag   = e_sq[head];
  assign chk_fault     = chk_valid && hit && !viol_valid;
  assign stall_squashed = stall_v && squash_valid && occ[stall_r] && (e_seq[stall_r] > squash_seq);

  always_comb begin
    n_com = '0;
    n_sq  = '0;
    occ   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      rel    = IW'(i) - head;
      occ[i] = CW'(rel) < cnt;
      if (occ[i] && commit_valid && e_seq[i] <= commit_seq) n_com = n_com + CW'(1);
      if (occ[i] && squash_valid && e_seq[i] > squash_seq)  n_sq  = n_sq + CW'(1);
    end
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = chk_start;
    span    = tail - chk_start;
    for (int k = 0; k < DEPTH; k++) begin
      pos = chk_start + IW'(k);
      if (!hit && IW'(k) < span && e_av[pos] &&
          e_addr[pos][ADDR_W-1:DROP_BITS] == chk_addr[ADDR_W-1:DROP_BITS]) begin
        hit     = 1'b1;
        hit_idx = pos;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head       <= '0;
      tail       <= '0;
      cnt        <= '0;
      e_av       <= '0;
      e_sqv      <= '0;
      viol_valid <= 1'b0;
      viol_idx   <= '0;
      viol_seq   <= '0;
      stall_v    <= 1'b0;
      stall_r    <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_seq[i]  <= '0;
        e_addr[i] <= '0;
        e_sq[i]   <= '0;
      end
    end else begin
      head <= head + IW'(n_com);
      cnt  <= cnt + CW'(alloc_fire) - n_com - n_sq;
      if (squash_valid)    tail <= tail - IW'(n_sq);
      else if (alloc_fire) tail <= tail + IW'(1);
      if (alloc_fire) begin
        e_seq[tail]  <= alloc_seq;
        e_sq[tail]   <= alloc_sq_tag;
        e_sqv[tail]  <= !alloc_sq_empty;
        e_av[tail]   <= 1'b0;
      end
      if (wb_valid) begin
        e_addr[wb_idx] <= wb_addr;
        e_av[wb_idx]   <= 1'b1;
      end
      if (chk_fault) begin
        viol_valid <= 1'b1;
        viol_idx   <= hit_idx;
        viol_seq   <= e_seq[hit_idx];
      end else if (viol_read) begin
        viol_valid <= 1'b0;
      end
      if (stall_set) begin
        stall_v <= 1'b1;
        stall_r <= stall_idx;
      end
      if (stall_release || stall_squashed) stall_v <= 1'b0;
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH - 1));
  p_refuse_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready && !squash_valid) |=> (tail == $past(tail)));
  p_fault_records_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fault |=> viol_valid);
  p_viol_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !viol_read) |=> (viol_valid && $stable(viol_idx) && $stable(viol_seq)));
  p_commit_shrinks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !alloc_valid) |=> (cnt <= $past(cnt)));
  p_squash_shrinks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> (cnt <= $past(cnt)));
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_release && !stall_set) |=> !stalled);

endmodule

// File: tb/sim_load_order_queue.sv
`timescale 1ns/1ps
module sim_load_order_queue;
  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, alloc_sq_empty = 0, wb_valid = 0, chk_valid = 0, viol_read = 0;
  logic commit_valid = 0, squash_valid = 0, stall_set = 0, stall_release = 0;
  logic [7:0] alloc_seq = 0, commit_seq = 0, squash_seq = 0;
  logic [2:0] alloc_sq_tag = 0, wb_idx = 0, chk_start = 0, stall_idx = 0;
  logic [31:0] wb_addr = 0, chk_addr = 0;
  logic alloc_ready, chk_fault, viol_valid, stalled, head_sq_valid;
  logic [2:0] lq_tail, viol_idx, head_sq_tag;
  logic [7:0] viol_seq, head_seq;
  logic [3:0] lq_count;
  int checks = 0, errors = 0;
  bit done = 0;
  bit has_addr [8];

  always #5 clk = ~clk;

  load_order_queue u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_alloc(input int seq, input int tag, input bit empty);
    alloc_valid = 1; alloc_seq = 8'(seq); alloc_sq_tag = 3'(tag); alloc_sq_empty = empty;
    tick;
    alloc_valid = 0;
  endtask

  task automatic do_wb(input int idx, input logic [31:0] a);
    wb_valid = 1; wb_idx = 3'(idx); wb_addr = a;
    tick;
    wb_valid = 0;
    has_addr[idx] = 1;
  endtask

  task automatic probe(input int s, input logic [31:0] a, output bit f);
    chk_valid = 1; chk_start = 3'(s); chk_addr = a;
    #1 f = chk_fault;
    chk_valid = 0;
  endtask

  task automatic check_clocked(input int s, input logic [31:0] a, output bit f);
    chk_valid = 1; chk_start = 3'(s); chk_addr = a;
    #1 f = chk_fault;
    tick;
    chk_valid = 0;
  endtask

  initial begin
    bit f;
    for (int i = 0; i < 8; i++) has_addr[i] = 0;
    repeat (2) tick;
    rst_n = 1;
    tick;
    check("R11 reset count", lq_count, 0);
    check("R1 reset ready", alloc_ready, 1);
    check("R7 reset viol", viol_valid, 0);
    check("R10 reset stall", stalled, 0);

    for (int i = 1; i <= 7; i++) begin
      do_alloc(i, i % 8, i == 1);
      check("R11 count after alloc", lq_count, i);
      check("R1 ready while filling", alloc_ready, i < 7);
    end
    do_alloc(50, 0, 0);
    check("R1 refused alloc count", lq_count, 7);
    check("R1 refused alloc tail", lq_tail, 7);
    check("R2 head seq", head_seq, 1);
    check("R2 invalid tag marker", head_sq_valid, 0);

    commit_valid = 1; commit_seq = 2; tick; commit_valid = 0;
    check("R8 commit count", lq_count, 5);
    check("R8 commit head", head_seq, 3);
    check("R2 tag valid", head_sq_valid, 1);
    check("R2 tag value", head_sq_tag, 3);

    do_wb(2, 32'h1000 + 2*256 + 2);
    do_wb(3, 32'h1000 + 3*256 + 3);
    do_wb(5, 32'h1000 + 5*256 + 5);
    for (int s = 2; s <= 7; s++)
      for (int t = 2; t <= 6; t++) begin
        probe(s, 32'h1000 + 32'(t)*256 + 32'h77, f);
        check($sformatf("R3 R4 sweep start %0d slot %0d", s, t), f, int'(has_addr[t] && t >= s));
      end

    do_wb(4, 32'h1233);
    probe(4, 32'h1300, f); check("R5 one past block", f, 0);
    probe(4, 32'h12FF, f); check("R5 top of block", f, 1);
    probe(4, 32'h11FF, f); check("R5 one below block", f, 0);

    check_clocked(2, 32'h12FF, f);
    check("R6 fault response", f, 1);
    check("R6 viol valid", viol_valid, 1);
    check("R6 first match idx", viol_idx, 2);
    check("R6 first match seq", viol_seq, 3);
    check_clocked(3, 32'h12FF, f);
    check("R7 no fault while pending", f, 0);
    check("R7 violator kept", viol_idx, 2);
    viol_read = 1; tick; viol_read = 0;
    check("R7 read clears", viol_valid, 0);
    check_clocked(3, 32'h12FF, f);
    check("R6 later start fault", f, 1);
    check("R6 later start idx", viol_idx, 4);
    check("R6 later start seq", viol_seq, 5);
    viol_read = 1; tick; viol_read = 0;

    stall_set = 1; stall_idx = 5; tick; stall_set = 0;
    check("R10 stall set", stalled, 1);
    squash_valid = 1; squash_seq = 6; alloc_valid = 1; alloc_seq = 99;
    tick;
    squash_valid = 0; alloc_valid = 0;
    check("R9 squash count", lq_count, 4);
    check("R9 squash tail, alloc dropped", lq_tail, 6);
    check("R10 stall kept", stalled, 1);
    squash_valid = 1; squash_seq = 5; tick; squash_valid = 0;
    check("R9 second squash count", lq_count, 3);
    check("R9 second squash tail", lq_tail, 5);
    check("R10 stall cleared by squash", stalled, 0);
    stall_set = 1; stall_idx = 2; tick; stall_set = 0;
    check("R10 stall set again", stalled, 1);
    stall_release = 1; tick; stall_release = 0;
    check("R10 release", stalled, 0);

    for (int i = 0; i < 4; i++) do_alloc(10 + i, i, 0);
    check("R1 wrapped tail", lq_tail, 1);
    check("R1 wrapped full", alloc_ready, 0);
    check("R11 wrapped count", lq_count, 7);
    do_wb(0, 32'h5000);
    probe(6, 32'h50AA, f); check("R4 walk wraps to slot 0", f, 1);
    probe(1, 32'h50AA, f); check("R4 start at tail checks nothing", f, 0);
    probe(6, 32'h1234, f); check("R4 slot before start excluded", f, 0);
    probe(2, 32'h1234, f); check("R4 slot at start included", f, 1);
    probe(5, 32'h1500, f); check("R3 realloc clears address", f, 0);

    commit_valid = 1; commit_seq = 255; tick; commit_valid = 0;
    check("R8 commit all count", lq_count, 0);
    check("R8 commit all ready", alloc_ready, 1);
    check("R8 tail unchanged", lq_tail, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule